// File: doc/BRIEF.md
# Periodic ADC Sampling Scheduler

This block starts conversions on a byte-wide successive-approximation ADC at exactly equal intervals, independent of host software latency. A free-running timer, clocked by the same clock that drives the converter, asserts the converter's chip-select and read strobes together once per programmed period. The strobes change only on the rising clock edge, clear of the falling edges on which the converter counts towards its sampling instant. The converter holds its input on the third falling edge after both strobes go low, so the programmed period is the sampling interval.

Once a conversion starts, the block waits for the converter's active-low busy line to fall and rise again. It captures the result byte on the next clock and releases the strobes. The byte is pushed into a small first-word-fall-through FIFO that the host drains at its own pace. The host never addresses the converter, so it cannot disturb a conversion that is in progress.

A conversion lasts 20 converter clocks. For that reason, any period below 24 clocks is raised to 24. When the FIFO is full, the new sample is discarded and a sticky overflow flag is set, which the host clears with a one-cycle pulse.

Top module: `adc_sample_sched`

## Requirements
- R1: After reset, both strobes are high (inactive), `empty` is 1, and `full` and `overflow` are 0.
- R2: `conv_cs_n` and `conv_rd_n` always carry the same value. Their falling edges are spaced exactly Peff clocks apart, where Peff is the value of `period` when that value is 24 or more.
- R3: When `period` is below 24, Peff is 24.
- R4: Once asserted, the strobes stay low until `conv_busy_n` has gone low and then high again. They return high on the second rising clock edge after `conv_busy_n` rises.
- R5: The byte present on `conv_data` when the strobes are released is written to the FIFO. `rd_data` shows the oldest stored byte whenever `empty` is 0, and a `rd_en` pulse removes that byte, so bytes leave in the order they were converted.
- R6: `full` is 1 when the FIFO holds DEPTH (default 4) bytes. A sample that completes while the FIFO is full is discarded, and the stored bytes are left unchanged.
- R7: `overflow` goes to 1 when a sample is discarded. It stays at 1 until a cycle with `ovf_clr` high; if a discard and a clear fall in the same cycle, the flag stays set.
- R8: `rd_en` while `empty` is 1 has no effect: the next byte to arrive is still read out first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; also drives the scheduler |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | PW (16) | Sampling interval in clocks |
| conv_cs_n | output | 1 | Converter chip select, active low |
| conv_rd_n | output | 1 | Converter read strobe, active low |
| conv_busy_n | input | 1 | Converter busy, low during a conversion |
| conv_data | input | DW (8) | Converter result byte |
| rd_en | input | 1 | Host pop request |
| rd_data | output | DW (8) | Oldest FIFO byte |
| empty | output | 1 | FIFO holds no byte |
| full | output | 1 | FIFO holds DEPTH bytes |
| overflow | output | 1 | Sticky: a sample was discarded |
| ovf_clr | input | 1 | Clears `overflow` |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 4-entry FIFO, a 16-bit period and a clamp at 24. A four-entry FIFO is filled and overflowed within a few hundred clocks. This makes the full, discard and sticky-flag corners cheap to reach. The bench sweeps the period across values below, at and above the clamp, and measures the spacing between strobe edges against max(period, 24). A behavioural converter model returns a byte computed arithmetically from its conversion index, so the order and content of every byte read out can be predicted.

// File: rtl/adc_sample_sched.sv
module adc_sample_sched #(
  parameter int DW = 8,
  parameter int DEPTH = 4,
  parameter int PW = 16,
  parameter int MIN_PERIOD = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  output logic          conv_cs_n,
  output logic          conv_rd_n,
  input  logic          conv_busy_n,
  input  logic [DW-1:0] conv_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          overflow,
  input  logic          ovf_clr
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {IDLE, ARMED, CONV, GRAB} st_t;
  st_t st;

  logic [PW-1:0] cnt, peff;
  logic          strobe;
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wptr, rptr;
  logic          push, pop;

  assign peff = (period < PW'(MIN_PERIOD)) ? PW'(MIN_PERIOD) : period;
  assign conv_cs_n = ~strobe;
  assign conv_rd_n = ~strobe;
  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign rd_data = mem[rptr[AW-1:0]];
  assign push = (st == GRAB);
  assign pop  = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= (cnt >= peff - PW'(1)) ? '0 : cnt + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      strobe <= 1'b0;
    end else begin
      case (st)
        IDLE:  if (cnt == '0) begin st <= ARMED; strobe <= 1'b1; end
        ARMED: if (!conv_busy_n) st <= CONV;
        CONV:  if (conv_busy_n) st <= GRAB;
        GRAB:  begin st <= IDLE; strobe <= 1'b0; end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[AW-1:0]] <= conv_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      overflow <= 1'b0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop) rptr <= rptr + 1'b1;
      if (push && full) overflow <= 1'b1;
      else if (ovf_clr) overflow <= 1'b0;
    end
  end

  // R2
  strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_cs_n) |-> cnt == PW'(1));

  // R4
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_cs_n && !conv_busy_n) |=> !conv_cs_n);

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr - rptr) <= (AW+1)'(DEPTH));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow);

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> $stable(rptr));
endmodule

// File: tb/test_adc_sample_sched.sv
module test_adc_sample_sched;
  logic clk = 0, rst_n = 0;
  logic [15:0] period = 16'd24;
  logic cs_n, rd_n, busy_n, rd_en = 0, ovf_clr = 0;
  logic [7:0] cdata, rd_data;
  logic empty, full, overflow;
  int tests = 0, fails = 0, cyc = 0, idx = 0, cc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_sample_sched i_adc_sample_sched (
    .clk(clk), .rst_n(rst_n), .period(period),
    .conv_cs_n(cs_n), .conv_rd_n(rd_n), .conv_busy_n(busy_n), .conv_data(cdata),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
    .overflow(overflow), .ovf_clr(ovf_clr));

  function automatic logic [7:0] f(input int k);
    return 8'(k * 37 + 5);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      idx <= 0; cc <= 0; busy_n <= 1'b1; cdata <= 8'h00;
    end else if (!cs_n) begin
      cc <= cc + 1;
      if (cc == 1) busy_n <= 1'b0;
      if (cc == 18) begin busy_n <= 1'b1; cdata <= f(idx); idx <= idx + 1; end
    end else cc <= 0;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic do_reset(input logic [15:0] p);
    period = p; rst_n = 0;
    repeat (3) tick;
    rst_n = 1;
  endtask

  task automatic wait_fall(output int at);
    logic prev;
    prev = cs_n;
    forever begin
      tick;
      if (prev && !cs_n) break;
      prev = cs_n;
    end
    at = cyc;
  endtask

  task automatic pop_one;
    rd_en = 1; tick; rd_en = 0;
  endtask

  initial begin
    int t0, t1, exp;
    logic prevb;
    int pl [6] = '{3, 23, 24, 25, 33, 40};
    do_reset(16'd24);
    rst_n = 0; tick;
    check("R1 cs_n", cs_n, 1); check("R1 rd_n", rd_n, 1);
    check("R1 empty", empty, 1); check("R1 full", full, 0);
    check("R1 overflow", overflow, 0);

    foreach (pl[i]) begin
      exp = (pl[i] < 24) ? 24 : pl[i];
      do_reset(16'(pl[i]));
      wait_fall(t0);
      for (int n = 0; n < 3; n++) begin
        wait_fall(t1);
        check(pl[i] < 24 ? "R3 clamp interval" : "R2 interval", t1 - t0, exp);
        check("R2 rd_n follows cs_n", rd_n, cs_n);
        t0 = t1;
      end
    end

    do_reset(16'd30);
    for (int n = 0; n < 3; n++) begin
      prevb = busy_n;
      forever begin tick; if (!prevb && busy_n) break; prevb = busy_n; end
      check("R4 low at busy rise", cs_n, 0);
      tick; check("R4 low one edge later", cs_n, 0);
      tick; check("R4 released", cs_n, 1);
      check("R4 rd_n released", rd_n, 1);
    end

    do_reset(16'd30);
    tick;
    pop_one;
    check("R8 still empty", empty, 1);
    for (int k = 0; k < 8; k++) begin
      while (empty) tick;
      check(k == 0 ? "R8 first byte after empty pop" : "R5 data", rd_data, f(k));
      pop_one;
      check("R5 empty after pop", empty, 1);
    end

    do_reset(16'd24);
    repeat (6 * 24 + 30) tick;
    check("R6 full", full, 1);
    check("R7 overflow set", overflow, 1);
    for (int k = 0; k < 4; k++) begin
      check("R6 kept byte", rd_data, f(k));
      pop_one;
    end
    check("R7 sticky", overflow, 1);
    ovf_clr = 1; tick; ovf_clr = 0;
    check("R7 cleared", overflow, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule